// File: doc/BRIEF.md
# SPI Slave Receive Path with Partial-Word Flush

This block is the receive half of an SPI slave. The three pins SCK, MOSI and active-low select pass through two-flop synchronisers into the system clock domain, where SCK rising edges are found. While the slave is selected, each rising edge shifts one MOSI bit into a word, most significant bit first. The word length comes from a configuration input. Each complete word is pushed into a small receive FIFO.

Clock pulses beyond the configured length are not rejected. A surplus bit simply starts the next word. When select is released part way through a word, the bits gathered so far are pushed as one more entry. They sit at the top of the word and are zero-filled below. The host sees no bit or clock count. It can only infer how much arrived from the number of entries, shown on a fill-level output. The system clock must run at least four times faster than SCK.

The read side is a valid/ready stream. `rd_valid` is high whenever the FIFO holds an entry. An entry leaves on any cycle where `rd_valid` and `rd_ready` are both high. While `rd_ready` is low the head entry is held, unchanged. The receive side cannot be stalled. A word that arrives while all entries are full is dropped and raises a sticky overflow flag.

Top module: `spi_rx_gather`

## Requirements
- R1: After reset, `rd_level` is 0, `rd_valid` is 0 and `ovf` is 0.
- R2: While selected, MOSI is sampled on each SCK rising edge, most significant bit first. After N bits one entry is pushed, holding the word in bits N-1..0 with every higher bit zero. N is `cfg_len` when that value is 1..MAX_W. A value of 0, or a value above MAX_W, selects MAX_W.
- R3: A bit that arrives after a full word becomes the most significant bit (position N-1) of a new word. No pulse is discarded.
- R4: When select is released after k bits of a word, with 0<k<N, one entry is pushed. It holds those k bits in positions N-1..N-k and zeros in positions N-k-1..0.
- R5: Releasing select with no bits gathered in the current word pushes nothing.
- R6: SCK edges while select is high (deselected) change neither the FIFO nor the next word received.
- R7: Entries leave in arrival order. `rd_valid` is high exactly when `rd_level` is nonzero. A pop occurs when `rd_valid` and `rd_ready` are both high. With `rd_ready` low, `rd_data` holds.
- R8: `rd_level` reports the number of stored entries, from 0 to DEPTH (8 by default).
- R9: A word pushed while the FIFO is full, with no pop that cycle, is dropped. It sets `ovf`, which stays high and leaves the stored entries unchanged.
- R10: `ovf_clr` high for a cycle clears `ovf`, unless a drop happens in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from master (asynchronous) |
| spi_mosi | input | 1 | Serial data from master (asynchronous) |
| spi_ss_n | input | 1 | Slave select, active low (asynchronous) |
| cfg_len | input | $clog2(MAX_W+1) | Word length in bits |
| rd_data | output | MAX_W | Head entry of the FIFO |
| rd_valid | output | 1 | FIFO holds at least one entry |
| rd_ready | input | 1 | Consumer accepts the head entry |
| rd_level | output | $clog2(DEPTH+1) | Number of stored entries |
| ovf | output | 1 | Sticky overflow flag |
| ovf_clr | input | 1 | Clears the overflow flag |

## Verification
The assertions check on every cycle the properties that follow from state alone:
- the fill level never exceeds the depth and moves down by one on a pop with no push;
- the head entry stays stable under back-pressure;
- the overflow flag rises only from a full FIFO and stays set until cleared;
- no push occurs after select has been released for a while.

The bit-level results need the bench's scenarios: MSB-first assembly, right alignment, clamping of the word-length setting, surplus bits wrapping into a new word, and the zero-filled partial flush. The bench sweeps every word length and every partial length for each word length, and computes the expected words arithmetically.

// File: rtl/spi_rx_gather_pkg.sv
package spi_rx_gather_pkg;

  // Effective word length: out-of-range settings select the maximum.
  function automatic int eff_len(input int cfg, input int max_w);
    if (cfg == 0 || cfg > max_w) return max_w;
    return cfg;
  endfunction

  // Index of the synchronised pins inside the synchroniser vector.
  localparam int PIN_SCK  = 0;
  localparam int PIN_MOSI = 1;
  localparam int PIN_SSN  = 2;
  localparam int PIN_CNT  = 3;

endpackage

// File: rtl/spi_rx_sync.sv
module spi_rx_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
    end else begin
      chain[0] <= d_async;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/spi_rx_assembler.sv
module spi_rx_assembler
  import spi_rx_gather_pkg::*;
#(
  parameter int MAX_W = 16,
  localparam int LW   = $clog2(MAX_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sck_s,
  input  logic             mosi_s,
  input  logic             sel_s,
  input  logic [LW-1:0]    cfg_len,
  output logic             push_v,
  output logic [MAX_W-1:0] push_d
);
  logic             sck_q, sel_q;
  logic [LW-1:0]    cnt;
  logic [MAX_W-1:0] sh, sh_next;
  logic [LW-1:0]    n_bits;
  logic             sck_rise, sel_on, sel_off;

  always_comb begin
    n_bits   = LW'(eff_len(int'(cfg_len), MAX_W));
    sck_rise = sck_s & ~sck_q & sel_s;
    sel_on   = sel_s & ~sel_q;
    sel_off  = ~sel_s & sel_q;
    sh_next  = (sh << 1) | MAX_W'(mosi_s);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= 1'b0;
      sel_q  <= 1'b0;
      cnt    <= '0;
      sh     <= '0;
      push_v <= 1'b0;
      push_d <= '0;
    end else begin
      sck_q  <= sck_s;
      sel_q  <= sel_s;
      push_v <= 1'b0;
      if (sel_on) begin
        cnt <= '0;
        sh  <= '0;
      end else if (sel_off) begin
        if (cnt != '0) begin
          push_v <= 1'b1;
          push_d <= sh << (n_bits - cnt);
        end
        cnt <= '0;
        sh  <= '0;
      end else if (sck_rise) begin
        if (cnt + LW'(1) >= n_bits) begin
          push_v <= 1'b1;
          push_d <= sh_next;
          cnt    <= '0;
          sh     <= '0;
        end else begin
          cnt <= cnt + LW'(1);
          sh  <= sh_next;
        end
      end
    end
  end
endmodule

// File: rtl/spi_rx_fifo.sv
module spi_rx_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_d,
  output logic [W-1:0]  rd_data,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [CW-1:0] level,
  output logic          ovf,
  input  logic          ovf_clr
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          pop, accept, drop;

  always_comb begin
    rd_valid = (level != '0);
    pop      = rd_valid & rd_ready;
    accept   = push & ((level != CW'(DEPTH)) | pop);
    drop     = push & ~accept;
    rd_data  = mem[rp];
  end

  function automatic logic [AW-1:0] inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (accept) mem[wp] <= push_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
      ovf   <= 1'b0;
    end else begin
      if (accept) wp <= inc(wp);
      if (pop)    rp <= inc(rp);
      level <= level + CW'(accept) - CW'(pop);
      if (drop)         ovf <= 1'b1;
      else if (ovf_clr) ovf <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_rx_gather.sv
module spi_rx_gather
  import spi_rx_gather_pkg::*;
#(
  parameter int MAX_W = 16,
  parameter int DEPTH = 8,
  localparam int LW   = $clog2(MAX_W + 1),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spi_sck,
  input  logic             spi_mosi,
  input  logic             spi_ss_n,
  input  logic [LW-1:0]    cfg_len,
  output logic [MAX_W-1:0] rd_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [CW-1:0]    rd_level,
  output logic             ovf,
  input  logic             ovf_clr
);
  logic [PIN_CNT-1:0] pins_a, pins_s;
  logic               sel_s;
  logic               asm_push;
  logic [MAX_W-1:0]   asm_data;

  always_comb begin
    pins_a[PIN_SCK]  = spi_sck;
    pins_a[PIN_MOSI] = spi_mosi;
    pins_a[PIN_SSN]  = spi_ss_n;
    sel_s            = ~pins_s[PIN_SSN];
  end

  spi_rx_sync #(
    .W(PIN_CNT), .STAGES(2), .RST_VAL(PIN_CNT'(1) << PIN_SSN)
  ) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(pins_a), .q_sync(pins_s)
  );

  spi_rx_assembler #(.MAX_W(MAX_W)) u_asm (
    .clk(clk), .rst_n(rst_n),
    .sck_s(pins_s[PIN_SCK]), .mosi_s(pins_s[PIN_MOSI]), .sel_s(sel_s),
    .cfg_len(cfg_len), .push_v(asm_push), .push_d(asm_data)
  );

  spi_rx_fifo #(.W(MAX_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(asm_push), .push_d(asm_data),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .level(rd_level), .ovf(ovf), .ovf_clr(ovf_clr)
  );
endmodule

// File: rtl/spi_rx_gather_chk.sv
module spi_rx_gather_chk #(
  parameter int MAX_W = 16,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel_s,
  input logic             asm_push,
  input logic [MAX_W-1:0] rd_data,
  input logic             rd_valid,
  input logic             rd_ready,
  input logic [CW-1:0]    rd_level,
  input logic             ovf,
  input logic             ovf_clr
);
  a_r8_level_max: assert property (@(posedge clk) disable iff (!rst_n)
    rd_level <= CW'(DEPTH));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

  a_r7_pop_step: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_ready && !asm_push |=> rd_level == $past(rd_level) - CW'(1));

  a_r9_ovf_from_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(rd_level) == CW'(DEPTH));

  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !ovf_clr |=> ovf);

  a_r6_idle_no_push: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_s && !$past(sel_s) && !$past(sel_s, 2) |-> !asm_push);
endmodule

bind spi_rx_gather spi_rx_gather_chk #(.MAX_W(MAX_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_s(sel_s), .asm_push(asm_push),
  .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .rd_level(rd_level), .ovf(ovf), .ovf_clr(ovf_clr)
);

// File: tb/spi_rx_gather_test.sv
`timescale 1ns/1ps
module spi_rx_gather_test;
  localparam int MAX_W = 16;
  localparam int DEPTH = 8;
  localparam int LW = $clog2(MAX_W + 1);
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, mosi = 1'b0, ss_n = 1'b1;
  logic [LW-1:0] cfg = LW'(8);
  logic [MAX_W-1:0] rd_data;
  logic rd_valid, rd_ready = 1'b0;
  logic [CW-1:0] rd_level;
  logic ovf, ovf_clr = 1'b0;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  spi_rx_gather #(.MAX_W(MAX_W), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_mosi(mosi), .spi_ss_n(ss_n),
    .cfg_len(cfg), .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_level(rd_level), .ovf(ovf), .ovf_clr(ovf_clr)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic select();
    ss_n = 1'b0; wait_clk(4);
  endtask

  task automatic deselect();
    wait_clk(4); ss_n = 1'b1; wait_clk(10);
  endtask

  task automatic send_bits(input int val, input int nb);
    for (int i = nb - 1; i >= 0; i--) begin
      mosi = val[i]; wait_clk(4);
      sck = 1'b1;    wait_clk(4);
      sck = 1'b0;
    end
  endtask

  task automatic pop_expect(input string req, input int exp);
    check(req, int'(rd_valid), 1);
    check(req, int'(rd_data), exp);
    rd_ready = 1'b1; wait_clk(1); rd_ready = 1'b0;
  endtask

  initial begin
    wait_clk(3);
    // R1: reset state
    check("R1 level", int'(rd_level), 0);
    check("R1 valid", int'(rd_valid), 0);
    check("R1 ovf", int'(ovf), 0);
    rst_n = 1'b1; wait_clk(4);

    // R2: full word for every length, plus clamped settings
    for (int n = 1; n <= MAX_W + 2; n++) begin
      int len, v;
      len = (n > MAX_W) ? MAX_W : n;
      cfg = (n == MAX_W + 1) ? LW'(0) : (n == MAX_W + 2) ? LW'(MAX_W + 3) : LW'(n);
      v = (n * 40503 + 12345) % (1 << len);
      select(); send_bits(v, len); deselect();
      check("R2 level one word", int'(rd_level), 1);
      pop_expect("R2 word", v);
      wait_clk(1);
    end

    // R4: every partial length for every word length
    for (int n = 2; n <= MAX_W; n++) begin
      for (int k = 1; k < n; k++) begin
        int p;
        cfg = LW'(n);
        p = (n * 7 + k * 13) % (1 << k);
        select(); send_bits(p, k); deselect();
        check("R4 level partial", int'(rd_level), 1);
        pop_expect("R4 partial", p << (n - k));
        wait_clk(1);
      end
    end

    // R3: surplus pulses open a new word
    cfg = LW'(8);
    select(); send_bits(9'h165, 9); deselect();
    check("R3 level", int'(rd_level), 2);
    pop_expect("R3 first word", 8'hB2);
    pop_expect("R3 surplus bit as MSB", 8'h80);
    cfg = LW'(3);
    select(); send_bits(7'b1011001, 7); deselect();
    check("R3 level n3", int'(rd_level), 3);
    pop_expect("R3 n3 w0", 5);
    pop_expect("R3 n3 w1", 4);
    pop_expect("R3 n3 tail", 4);

    // R5: select and release with no clocks
    select(); deselect();
    check("R5 empty release", int'(rd_level), 0);

    // R6: clocks while deselected are ignored
    cfg = LW'(4);
    send_bits(4'hF, 4); wait_clk(10);
    check("R6 no entry", int'(rd_level), 0);
    select(); send_bits(4'h6, 4); deselect();
    check("R6 next word level", int'(rd_level), 1);
    pop_expect("R6 next word clean", 4'h6);

    // R7/R8/R9: fill past depth in one selection
    select();
    for (int i = 1; i <= DEPTH + 1; i++) send_bits(i, 4);
    deselect();
    check("R8 level full", int'(rd_level), DEPTH);
    check("R9 ovf set", int'(ovf), 1);
    wait_clk(5);
    check("R7 hold data", int'(rd_data), 1);
    for (int i = 1; i <= DEPTH; i++) begin
      pop_expect("R7 order", i);
      check("R8 level drain", int'(rd_level), DEPTH - i);
    end
    check("R7 valid low empty", int'(rd_valid), 0);
    check("R9 ovf sticky", int'(ovf), 1);

    // R10: clear
    ovf_clr = 1'b1; wait_clk(1); ovf_clr = 1'b0; wait_clk(1);
    check("R10 ovf cleared", int'(ovf), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule